// File: doc/BRIEF.md
# Full-Step Stepper Phase Generator

This block drives the four coil lines of a two-phase stepper motor in full-step mode. A single free-running up-counter sweeps from zero to a programmable period and wraps. Two toggle flip-flops are flipped at two compare points of that counter: the first pair of coil lines (A and its complement C) flips when the count is 1, the second pair (B and its complement D) flips when the count is half the period plus one. Each pair therefore completes one full square wave every two counter periods, and the second pair trails the first by a quarter of that wave, giving the four-state full-step sequence.

Speed is set by the period. A new period is written into a shadow register with a load strobe and only becomes active when the counter wraps, so no period is ever shortened or lengthened while it runs. Direction is selected by the starting polarity of the second pair relative to the first; it may only be changed while the block is disabled, and changing it restarts the sequence from its initial pattern. A one-cycle step strobe marks every edge on the coil lines.

Top module: `stepper_phase_gen`

## Requirements
- R1: During and directly after reset the count is 0, the active and shadow periods equal DEF_PERIOD, the direction is forward, the outputs are A=1, B=0, C=0, D=1 and step is 0.
- R2: C is always the logical inverse of A and D is always the logical inverse of B.
- R3: While enabled the counter advances by one per clock from 0 up to the active period and then returns to 0; A (and C) flip on the clock edge at which the count equals 1, once per counter period.
- R4: B (and D) flip on the clock edge at which the count equals floor(active period / 2) + 1, so A and B never change on the same edge.
- R5: step is 1 for exactly the cycle following an edge that flipped A or B, and 0 otherwise.
- R6: While en is 0 the counter, A, B, C and D hold their values and step stays 0 (apart from a direction reload, R7).
- R7: While en is 0, a dir value different from the stored direction is taken: the count returns to 0 and the outputs reload to A=1, B=dir, C=0, D=~dir (dir=1 is reverse: A=1, B=1, C=0, D=0).
- R8: A change of dir while en is 1 has no effect on the outputs or the count.
- R9: load copies period_in into the shadow register; the active period and the B/D compare point take the shadow value only on the edge where the counter wraps.
- R10: A period_in value below 4 is stored as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low freezes the counter and outputs |
| dir | input | 1 | Direction: 0 forward, 1 reverse; taken only while disabled |
| load | input | 1 | Writes period_in into the shadow period |
| period_in | input | CNT_W | New period value (clamped to at least 4) |
| ph_a | output | 1 | Coil line A |
| ph_b | output | 1 | Coil line B |
| ph_c | output | 1 | Coil line C, inverse of A |
| ph_d | output | 1 | Coil line D, inverse of B |
| step | output | 1 | One-cycle strobe after each coil edge |

## Verification
The hardest case to reach from the ports is the buffered period change: the default period is long, so the first shadow write only shows up after several thousand enabled cycles, and a later write must land in the middle of a running period to show that the current period still finishes at its old length. The bench runs a reference model of the counter cycle by cycle, lets the default period expire once, then issues loads mid-period, a clamped load, an enabled direction flip, freezes and a disabled reverse reload, comparing every coil line and the strobe on every cycle.

// File: rtl/stepper_phase_gen.sv
module stepper_phase_gen #(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dir,
  input  logic             load,
  input  logic [CNT_W-1:0] period_in,
  output logic             ph_a,
  output logic             ph_b,
  output logic             ph_c,
  output logic             ph_d,
  output logic             step
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(4);
  localparam logic [CNT_W-1:0] DEF_P = CNT_W'(DEF_PERIOD < 4 ? 4 : DEF_PERIOD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt, act, cmp_bd, shadow;
  logic             ac, bd, dir_q;

  wire hit_ac  = (cnt == ONE);
  wire hit_bd  = (cnt == cmp_bd);
  wire wrap    = (cnt == act);
  wire dir_chg = !en && (dir != dir_q);
  wire [CNT_W-1:0] shadow_cmp = (shadow >> 1) + ONE;
  wire [CNT_W-1:0] period_cl  = (period_in < MIN_P) ? MIN_P : period_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      act    <= DEF_P;
      cmp_bd <= (DEF_P >> 1) + ONE;
      shadow <= DEF_P;
      ac     <= 1'b1;
      bd     <= 1'b0;
      dir_q  <= 1'b0;
      step   <= 1'b0;
    end else begin
      if (load) shadow <= period_cl;
      step <= en && (hit_ac || hit_bd);
      if (en) begin
        if (hit_ac) ac <= ~ac;
        if (hit_bd) bd <= ~bd;
        if (wrap) begin
          cnt    <= '0;
          act    <= shadow;
          cmp_bd <= shadow_cmp;
        end else begin
          cnt <= cnt + ONE;
        end
      end else if (dir_chg) begin
        dir_q <= dir;
        cnt   <= '0;
        ac    <= 1'b1;
        bd    <= dir;
      end
    end
  end

  assign ph_a = ac;
  assign ph_c = ~ac;
  assign ph_b = bd;
  assign ph_d = ~bd;
endmodule

// File: rtl/stepper_phase_gen_chk.sv
module stepper_phase_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             dir,
  input logic             dir_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act,
  input logic             ph_a,
  input logic             ph_b,
  input logic             ph_c,
  input logic             ph_d,
  input logic             step
);
  p_complement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_c == ~ph_a) && (ph_d == ~ph_b));

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == act) |=> (cnt == '0));

  p_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> !((ph_a != $past(ph_a)) && (ph_b != $past(ph_b))));

  p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (step == ((ph_a != $past(ph_a)) || (ph_b != $past(ph_b)))));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && dir == dir_q) |=> ($stable(cnt) && $stable(ph_a) && $stable(ph_b) && !step));

  p_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act >= CNT_W'(4));
endmodule

bind stepper_phase_gen stepper_phase_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .dir_q(dir_q),
  .cnt(cnt), .act(act), .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
  .ph_d(ph_d), .step(step)
);

// File: tb/stepper_phase_gen_tb.sv
module stepper_phase_gen_tb;
  localparam int W = 16;
  localparam int DEF = 4000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, dir = 1'b0, load = 1'b0;
  logic [W-1:0] period_in = '0;
  logic ph_a, ph_b, ph_c, ph_d, step;

  always #4 clk = ~clk;

  stepper_phase_gen #(.CNT_W(W), .DEF_PERIOD(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .load(load),
    .period_in(period_in), .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
    .ph_d(ph_d), .step(step));

  typedef struct {
    logic [4:0] v;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_cnt, m_act, m_sh;
  logic m_ac, m_bd, m_dir, m_step;

  task automatic check(input string tag, input logic [4:0] act_v, input logic [4:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: {a,b,c,d,step} actual %b expected %b at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic cyc(input logic e, input logic d, input logic l, input int p, input string tag);
    exp_t it;
    int cmp;
    @(negedge clk);
    en = e; dir = d; load = l; period_in = W'(p);
    cmp = m_act / 2 + 1;
    if (e) begin
      m_step = (m_cnt == 1) || (m_cnt == cmp);
      if (m_cnt == 1) m_ac = ~m_ac;
      if (m_cnt == cmp) m_bd = ~m_bd;
      if (m_cnt == m_act) begin m_cnt = 0; m_act = m_sh; end
      else m_cnt++;
    end else begin
      m_step = 1'b0;
      if (d != m_dir) begin m_dir = d; m_cnt = 0; m_ac = 1'b1; m_bd = d; end
    end
    if (l) m_sh = (p < 4) ? 4 : p;
    it.v = {m_ac, m_bd, ~m_ac, ~m_bd, m_step};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input int n, input logic e, input logic d, input string tag);
    for (int i = 0; i < n; i++) cyc(e, d, 1'b0, 0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check(it.tag, {ph_a, ph_b, ph_c, ph_d, step}, it.v);
      end
    end
  end

  initial begin : driver
    m_cnt = 0; m_act = DEF; m_sh = DEF; m_ac = 1'b1; m_bd = 1'b0; m_dir = 1'b0; m_step = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {ph_a, ph_b, ph_c, ph_d, step}, 5'b10010);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {ph_a, ph_b, ph_c, ph_d, step}, 5'b10010);
    // R9: shadow written early, old long period must run out first
    cyc(1'b1, 1'b0, 1'b1, 10, "R9 load during default period");
    run(DEF + 5, 1'b1, 1'b0, "R9 default period runs out");
    // R3 R4 R5: several periods at period 10
    run(60, 1'b1, 1'b0, "R3 R4 R5 forward at period 10");
    // R9: mid-period load of 11
    run(4, 1'b1, 1'b0, "R9 approach");
    cyc(1'b1, 1'b0, 1'b1, 11, "R9 mid-period load");
    run(50, 1'b1, 1'b0, "R9 period 11 after wrap");
    // R10: clamp
    cyc(1'b1, 1'b0, 1'b1, 2, "R10 load below minimum");
    run(40, 1'b1, 1'b0, "R10 clamped period 4");
    cyc(1'b1, 1'b0, 1'b1, 0, "R10 load zero");
    run(30, 1'b1, 1'b0, "R10 clamped period 4 again");
    cyc(1'b1, 1'b0, 1'b1, 9, "R3 odd period load");
    run(45, 1'b1, 1'b0, "R4 odd period 9");
    // R6: freeze
    run(7, 1'b1, 1'b0, "R6 approach");
    run(20, 1'b0, 1'b0, "R6 hold while disabled");
    run(25, 1'b1, 1'b0, "R6 resume");
    // R8: dir flips while enabled
    run(15, 1'b1, 1'b1, "R8 dir high while enabled");
    run(15, 1'b1, 1'b0, "R8 dir low while enabled");
    // R7: reverse reload while disabled
    run(3, 1'b0, 1'b0, "R6 stop");
    run(5, 1'b0, 1'b1, "R7 reverse reload");
    run(50, 1'b1, 1'b1, "R7 reverse run");
    run(3, 1'b0, 1'b0, "R7 forward reload");
    run(30, 1'b1, 1'b0, "R7 forward run R2");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin : finish_ctl
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule